// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus transaction at a time on a bus whose low address byte and data byte share the same lines. A client presents a cycle kind, an address and, for writes, a data byte. The sequencer steps through its clock states in order. The first state pulses an address strobe while the low address byte sits on the shared lines. The middle states drive the read or write strobe. For reads, the byte on the shared lines is sampled at the end of the transfer. Instruction fetches add one extra internal state with no bus activity.

A slow target stretches the transfer phase by holding its acknowledge input low. An external bus master can ask for the bus. The request is granted only between transactions. While it is granted, every output the sequencer drives is released through its enable outputs, and no new transaction starts until the request is withdrawn.

Top module: `bus_cycle_seq`

## Requirements
- R1: In the first state of every transaction, `addr_strobe` is high for exactly one cycle. In that state `mux_oe` is 1, `mux_out` carries address bits [7:0], `addr_hi` carries address bits [15:8], and both strobes are high.
- R2: With `xfer_ok` held high, a fetch (kind 0) spans four states and every other kind spans three. `done` pulses for one cycle, in the cycle after the last state.
- R3: `cyc_status` is 2'b11 for a fetch (kind 0), 2'b10 for memory read (kind 1) and I/O read (kind 3), 2'b01 for memory write (kind 2) and I/O write (kind 4). It is 2'b00 when no transaction is in progress.
- R4: `io_space` is 1 during I/O kinds (3, 4). It is 0 during memory kinds and when no transaction is in progress.
- R5: In read kinds (0, 1, 3), `read_en_n` is 0 from the second state through the transfer end, `write_en_n` stays 1 and `mux_oe` is 0. In the fourth state of a fetch, both strobes are 1 and `mux_oe` is 0.
- R6: In write kinds (2, 4), `write_en_n` is 0 from the second state through the transfer end, `read_en_n` stays 1, `mux_oe` is 1 and `mux_out` carries the write byte.
- R7: When `xfer_ok` is sampled low at the end of the second state or of a wait state, one more wait state follows and the active strobe is held.
- R8: For read kinds, `mux_in` is sampled at the last edge of the transfer phase and appears on `rdata` while `done` is high.
- R9: When `bus_req` is high at a transaction boundary (idle, or the last state of a transaction), `bus_grant` goes high in the next cycle and no transaction starts. A `bus_req` raised mid-transaction does not shorten that transaction.
- R10: While `bus_grant` is high, `mux_oe` and `ctl_oe` are 0 and both strobes are 1. When `bus_req` falls, the block spends one idle cycle with `ctl_oe` high before it can accept a request.
- R11: I/O kinds put address bits [7:0] (the port number) on both `addr_hi` and the low address phase.
- R12: Requests with kind codes 5 to 7 are ignored. The block stays idle and `addr_strobe` and `done` stay low.
- R13: A valid request present at the last state of a transaction starts its first state in the very next cycle.
- R14: While reset is held, the block is idle. `addr_strobe`, `mux_oe`, `bus_grant` and `done` are 0, and the strobes and `ctl_oe` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transaction request |
| req_kind | input | 3 | Cycle kind code (0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write) |
| req_addr | input | ADDR_W | Transaction address; bits [7:0] are the port for I/O kinds |
| req_wdata | input | DATA_W | Write byte |
| xfer_ok | input | 1 | Target acknowledge; low inserts wait states |
| bus_req | input | 1 | External request for the bus |
| addr_hi | output | ADDR_W-DATA_W | Upper address bits |
| mux_out | output | DATA_W | Shared lines, driven value |
| mux_oe | output | 1 | Drive enable for the shared lines |
| mux_in | input | DATA_W | Shared lines, received value |
| addr_strobe | output | 1 | Address phase marker |
| read_en_n | output | 1 | Read strobe, active low |
| write_en_n | output | 1 | Write strobe, active low |
| io_space | output | 1 | 1 for I/O space, 0 for memory |
| cyc_status | output | 2 | Cycle status code |
| ctl_oe | output | 1 | Drive enable for upper address and control outputs |
| rdata | output | DATA_W | Captured read byte |
| done | output | 1 | Transaction complete pulse |
| bus_grant | output | 1 | Bus released to external master |

## Verification
The bench builds the block with its default 16-bit address, 8-bit data and the fetch decode state enabled. This keeps every kind code within a short loop. It sweeps all five legal kinds against zero to three wait states and three address patterns. The sweep covers the all-zero and all-one address corners and the I/O port duplication. Separate runs cover a grant requested mid-transaction and from idle, the three unused kind codes, and a back-to-back start at a transaction boundary.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      K_FETCH = 3'd0,
      K_MRD   = 3'd1,
      K_MWR   = 3'd2,
      K_IORD  = 3'd3,
      K_IOWR  = 3'd4
   } cyc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5,
      ST_HOLD = 3'd6
   } tstate_e;

   function automatic logic kind_ok(input logic [2:0] k);
      return (k <= 3'd4);
   endfunction

   function automatic logic kind_reads(input logic [2:0] k);
      return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
   endfunction

   function automatic logic kind_io(input logic [2:0] k);
      return (k == K_IORD) || (k == K_IOWR);
   endfunction

   function automatic logic [1:0] kind_status(input logic [2:0] k);
      case (k)
         K_FETCH:        return 2'b11;
         K_MRD, K_IORD:  return 2'b10;
         K_MWR, K_IOWR:  return 2'b01;
         default:        return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/bcs_req_latch.sv
module bcs_req_latch
   import bcs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        kind_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [2:0]        kind_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] port_num;
   logic [HI_W-1:0]   io_hi;
   logic [ADDR_W-1:0] formed_addr;

   assign port_num = addr_in[DATA_W-1:0];

   // Port number widened or narrowed onto the upper address field.
   generate
      if (HI_W == DATA_W) begin : g_hi_same
         assign io_hi = port_num;
      end else if (HI_W > DATA_W) begin : g_hi_wide
         assign io_hi = {{(HI_W-DATA_W){1'b0}}, port_num};
      end else begin : g_hi_narrow
         assign io_hi = port_num[HI_W-1:0];
      end
   endgenerate

   assign formed_addr = kind_io(kind_in) ? {io_hi, port_num} : addr_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= 3'd0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         kind_q  <= kind_in;
         addr_q  <= formed_addr;
         wdata_q <= wdata_in;
      end
   end

endmodule

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
   import bcs_pkg::*;
#(
   parameter bit FETCH_DECODE_ST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid_i,
   input  logic [2:0] req_kind_i,
   input  logic [2:0] cur_kind_i,
   input  logic       ready_i,
   input  logic       hold_i,
   output tstate_e    st_q,
   output logic       load_o,
   output logic       last_o,
   output logic       hlda_o
);
   tstate_e st_d;
   logic    t3_is_last;
   logic    boundary;
   logic    accept;

   generate
      if (FETCH_DECODE_ST) begin : g_fetch_long
         assign t3_is_last = (cur_kind_i != K_FETCH);
      end else begin : g_fetch_short
         assign t3_is_last = 1'b1;
      end
   endgenerate

   assign last_o   = ((st_q == ST_T3) && t3_is_last) || (st_q == ST_T4);
   assign boundary = (st_q == ST_IDLE) || last_o;
   assign accept   = req_valid_i && kind_ok(req_kind_i) && !hold_i;
   assign load_o   = boundary && accept;
   assign hlda_o   = (st_q == ST_HOLD);

   always_comb begin
      st_d = st_q;
      if (boundary) begin
         if (hold_i)      st_d = ST_HOLD;
         else if (accept) st_d = ST_T1;
         else             st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_T1:        st_d = ST_T2;
            ST_T2, ST_TW: st_d = ready_i ? ST_T3 : ST_TW;
            ST_T3:        st_d = ST_T4;
            ST_HOLD:      st_d = hold_i ? ST_HOLD : ST_IDLE;
            default:      st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_T2 || st_q == ST_TW) && !ready_i) |=> (st_q == ST_TW)); // R7
   AST_FETCH_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
      (FETCH_DECODE_ST && st_q == ST_T3 && cur_kind_i == K_FETCH) |=> (st_q == ST_T4)); // R2
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hlda_o) |-> $past(hold_i)); // R9
   AST_BAD_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && req_valid_i && !kind_ok(req_kind_i)) |=> (st_q != ST_T1)); // R12

endmodule

// File: rtl/bcs_bus_drive.sv
module bcs_bus_drive
   import bcs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tstate_e           st_i,
   input  logic              last_i,
   input  logic [2:0]        kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] mux_in,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0] mux_out,
   output logic              mux_oe,
   output logic              addr_strobe,
   output logic              read_en_n,
   output logic              write_en_n,
   output logic              io_space,
   output logic [1:0]        cyc_status,
   output logic              ctl_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic active;
   logic data_phase;
   logic reads;

   assign active     = (st_i == ST_T1) || (st_i == ST_T2) || (st_i == ST_TW) ||
                       (st_i == ST_T3) || (st_i == ST_T4);
   assign data_phase = (st_i == ST_T2) || (st_i == ST_TW) || (st_i == ST_T3);
   assign reads      = kind_reads(kind_i);

   assign addr_strobe = (st_i == ST_T1);
   assign mux_oe      = (st_i == ST_T1) || (data_phase && !reads);
   assign mux_out     = (st_i == ST_T1) ? addr_i[DATA_W-1:0] : wdata_i;
   assign addr_hi     = addr_i[ADDR_W-1:DATA_W];
   assign read_en_n   = !(data_phase && reads);
   assign write_en_n  = !(data_phase && !reads);
   assign io_space    = active && kind_io(kind_i);
   assign cyc_status  = active ? kind_status(kind_i) : 2'b00;
   assign ctl_oe      = (st_i != ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         done  <= 1'b0;
      end else begin
         done <= last_i;
         if (st_i == ST_T3 && reads) rdata <= mux_in;
      end
   end

   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> !addr_strobe); // R1
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 16,
   parameter bit FETCH_DECODE_ST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [2:0]               req_kind,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W-1:0]        req_wdata,
   input  logic                     xfer_ok,
   input  logic                     bus_req,
   output logic [ADDR_W-DATA_W-1:0] addr_hi,
   output logic [DATA_W-1:0]        mux_out,
   output logic                     mux_oe,
   input  logic [DATA_W-1:0]        mux_in,
   output logic                     addr_strobe,
   output logic                     read_en_n,
   output logic                     write_en_n,
   output logic                     io_space,
   output logic [1:0]               cyc_status,
   output logic                     ctl_oe,
   output logic [DATA_W-1:0]        rdata,
   output logic                     done,
   output logic                     bus_grant
);
   localparam int HI_W = ADDR_W - DATA_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("bus_cycle_seq: DATA_W must be positive");
      end
      if (HI_W < 1) begin : g_bad_addr
         $error("bus_cycle_seq: ADDR_W must exceed DATA_W");
      end
   endgenerate

   tstate_e           st;
   logic              load;
   logic              last;
   logic [2:0]        kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   bcs_req_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .kind_in  (req_kind),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .kind_q   (kind_q),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q)
   );

   bcs_tstate_fsm #(.FETCH_DECODE_ST(FETCH_DECODE_ST)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_kind_i  (req_kind),
      .cur_kind_i  (kind_q),
      .ready_i     (xfer_ok),
      .hold_i      (bus_req),
      .st_q        (st),
      .load_o      (load),
      .last_o      (last),
      .hlda_o      (bus_grant)
   );

   bcs_bus_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drive (
      .clk         (clk),
      .rst_n       (rst_n),
      .st_i        (st),
      .last_i      (last),
      .kind_i      (kind_q),
      .addr_i      (addr_q),
      .wdata_i     (wdata_q),
      .mux_in      (mux_in),
      .addr_hi     (addr_hi),
      .mux_out     (mux_out),
      .mux_oe      (mux_oe),
      .addr_strobe (addr_strobe),
      .read_en_n   (read_en_n),
      .write_en_n  (write_en_n),
      .io_space    (io_space),
      .cyc_status  (cyc_status),
      .ctl_oe      (ctl_oe),
      .rdata       (rdata),
      .done        (done)
   );

   AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_grant |-> (!mux_oe && !ctl_oe && read_en_n && write_en_n && !addr_strobe)); // R10
   AST_GRANT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant) |-> ($past(done) == 1'b0 || $past(bus_req))); // R9

endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic        xfer_ok = 1'b1;
   logic        bus_req = 1'b0;
   logic [7:0]  mux_in = 8'h0;
   logic [7:0]  addr_hi, mux_out, rdata;
   logic        mux_oe, addr_strobe, read_en_n, write_en_n, io_space, ctl_oe, done, bus_grant;
   logic [1:0]  cyc_status;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   bus_cycle_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .xfer_ok(xfer_ok), .bus_req(bus_req),
      .addr_hi(addr_hi), .mux_out(mux_out), .mux_oe(mux_oe), .mux_in(mux_in),
      .addr_strobe(addr_strobe), .read_en_n(read_en_n), .write_en_n(write_en_n),
      .io_space(io_space), .cyc_status(cyc_status), .ctl_oe(ctl_oe), .rdata(rdata),
      .done(done), .bus_grant(bus_grant)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [1:0] exp_stat(input int k);
      case (k)
         0: return 2'b11;
         1, 3: return 2'b10;
         default: return 2'b01;
      endcase
   endfunction

   function automatic bit exp_rd(input int k);
      return (k == 0) || (k == 1) || (k == 3);
   endfunction

   task automatic chk_data(input int k, input logic [7:0] wd, input string ph);
      chk({ph, " R1 strobe low"}, addr_strobe, 0);
      if (exp_rd(k)) begin
         chk({ph, " R5 rd"}, read_en_n, 0);
         chk({ph, " R5 wr"}, write_en_n, 1);
         chk({ph, " R5 oe"}, mux_oe, 0);
      end else begin
         chk({ph, " R6 wr"}, write_en_n, 0);
         chk({ph, " R6 rd"}, read_en_n, 1);
         chk({ph, " R6 oe"}, mux_oe, 1);
         chk({ph, " R6 data"}, mux_out, wd);
      end
      chk({ph, " R3 status"}, cyc_status, exp_stat(k));
      chk({ph, " R2 done"}, done, 0);
   endtask

   task automatic run_cyc(input int k, input logic [15:0] a, input logic [7:0] wd,
                          input int nw, input logic [7:0] rv, input bit hold_mid);
      logic [7:0] hi;
      hi = (k >= 3) ? a[7:0] : a[15:8];
      req_valid = 1'b1; req_kind = 3'(k); req_addr = a; req_wdata = wd;
      xfer_ok = 1'b1; mux_in = rv;
      step();
      req_valid = 1'b0;
      // first state
      chk("R1 strobe", addr_strobe, 1);
      chk("R1 oe", mux_oe, 1);
      chk("R1 low addr", mux_out, a[7:0]);
      chk("R1 high addr", addr_hi, hi);
      chk("R1 rd idle", read_en_n, 1);
      chk("R1 wr idle", write_en_n, 1);
      chk("R3 status", cyc_status, exp_stat(k));
      chk("R4 space", io_space, (k >= 3));
      if (k >= 3) chk("R11 port dup", addr_hi, a[7:0]);
      if (hold_mid) bus_req = 1'b1;
      step();
      chk_data(k, wd, "T2");
      xfer_ok = (nw == 0);
      step();
      for (int i = 0; i < nw; i++) begin
         chk_data(k, wd, "R7 wait");
         xfer_ok = (i == nw - 1);
         step();
      end
      chk_data(k, wd, "T3");
      xfer_ok = 1'b1;
      step();
      if (k == 0) begin
         chk("R5 T4 rd", read_en_n, 1);
         chk("R5 T4 wr", write_en_n, 1);
         chk("R5 T4 oe", mux_oe, 0);
         chk("R2 T4 done", done, 0);
         step();
      end
      chk("R2 done", done, 1);
      if (exp_rd(k)) chk("R8 rdata", rdata, rv);
      if (hold_mid) begin
         chk("R9 grant", bus_grant, 1);
         chk("R10 ctl oe", ctl_oe, 0);
         chk("R10 mux oe", mux_oe, 0);
         chk("R10 rd", read_en_n, 1);
         chk("R10 wr", write_en_n, 1);
         req_valid = 1'b1; req_kind = 3'd1;
         step();
         chk("R9 grant held", bus_grant, 1);
         chk("R9 no start", addr_strobe, 0);
         bus_req = 1'b0;
         req_valid = 1'b0;
         step();
         chk("R10 release", bus_grant, 0);
         chk("R10 ctl back", ctl_oe, 1);
         chk("R10 idle", addr_strobe, 0);
      end else begin
         chk("R9 no grant", bus_grant, 0);
         chk("R3 idle status", cyc_status, 0);
         chk("R4 idle space", io_space, 0);
      end
   endtask

   initial begin
      logic [15:0] av;
      logic [7:0] wv;
      #1;
      step();
      chk("R14 strobe", addr_strobe, 0);
      chk("R14 oe", mux_oe, 0);
      chk("R14 grant", bus_grant, 0);
      chk("R14 done", done, 0);
      chk("R14 rd", read_en_n, 1);
      chk("R14 wr", write_en_n, 1);
      chk("R14 ctl", ctl_oe, 1);
      rst_n = 1'b1;
      step();

      for (int k = 0; k < 5; k++)
         for (int nw = 0; nw < 4; nw++)
            for (int ai = 0; ai < 3; ai++) begin
               av = (ai == 0) ? 16'h0000 : (ai == 1) ? 16'hFFFF : 16'(16'h1357 * (k + 1) + nw * 16'h0F1);
               wv = 8'(8'h3C + k * 17 + nw * 5 + ai);
               run_cyc(k, av, wv, nw, ~wv, (nw == 1 && ai == 2));
               step();
            end

      // grant from idle
      bus_req = 1'b1;
      step();
      chk("R9 idle grant", bus_grant, 1);
      bus_req = 1'b0;
      step();
      chk("R10 idle release", bus_grant, 0);

      // unused kind codes
      for (int k = 5; k < 8; k++) begin
         req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h4242;
         step();
         chk("R12 no strobe", addr_strobe, 0);
         step();
         chk("R12 no done", done, 0);
         chk("R12 no oe", mux_oe, 0);
      end
      req_valid = 1'b0;
      step();

      // back-to-back: write then read chained at the boundary
      req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'hBEEF; req_wdata = 8'h5A;
      step();
      req_kind = 3'd1; req_addr = 16'h1234; mux_in = 8'hC3;
      step();
      step();
      chk("R13 last is write", write_en_n, 0);
      step();
      req_valid = 1'b0;
      chk("R13 chained start", addr_strobe, 1);
      chk("R13 done together", done, 1);
      chk("R13 new addr", mux_out, 8'h34);
      step();
      step();
      chk("R13 read strobe", read_en_n, 0);
      step();
      chk("R13 read done", done, 1);
      chk("R8 chained rdata", rdata, 8'hC3);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule